// File: doc/BRIEF.md
# DMA Bus Request Controller

This block decides when a single-channel DMA engine takes the system bus from the CPU and when it gives it back. It drives an active-low request toward the CPU, watches the active-low acknowledge that comes back, and while it holds the bus it issues one transfer strobe per byte moved. Actual memory or I/O cycles are left to the datapath that consumes the strobe.

A request goes out only when the channel is enabled, a ready condition is present (the device ready line or a force-ready command), the channel's own interrupt is not under service and acknowledge has returned high. Three transfer modes set the rules for releasing the bus. Byte mode gives it back after every byte. Burst mode keeps it until ready drops. Continuous mode keeps it through ready drops and simply pauses. Two programmable stops add further release points: a byte match (burst and continuous only) and end of block (all modes). Either stop raises an interrupt. The interrupt blocks further requests until a return-from-interrupt pulse arrives.

A block-length counter is loaded by the CPU and counts down on each strobe. Sticky flags record end of block and byte match until the CPU clears them.

Top module: `dma_busreq_ctrl`

## Requirements
- R1: `bus_req_n` falls only in the cycle after one in which `chan_en` is 1, `dev_ready` or `force_ready` is 1, `irq` is 0 and `bus_ack_n` is 1. It stays high while `chan_en` is 0 or while both ready sources are 0.
- R2: `xfer_stb` is 1 only while `bus_req_n` and `bus_ack_n` are both 0 and a ready source is 1. `bus_req_n` stays low for as long as the bus is held.
- R3: With `mode` = 2'b00 (byte), `bus_req_n` goes high in the cycle after every strobe.
- R4: With `mode` = 2'b00 or 2'b01 (burst), `bus_req_n` goes high in the cycle after a cycle in which the bus is held and both ready sources are 0.
- R5: With `mode` = 2'b10 or 2'b11 (continuous), a ready loss while the bus is held keeps `bus_req_n` low and stops strobes. Strobes resume when ready returns.
- R6: In burst or continuous mode with `stop_on_match` = 1, a strobe with `match_hit` = 1 releases the bus in the next cycle. With `stop_on_match` = 0, or in byte mode, a match does not cause this stop.
- R7: With `stop_on_eob` = 1, the strobe that brings the block counter from 1 to 0 releases the bus in any mode. With `stop_on_eob` = 0, transfers go on and the counter holds at 0.
- R8: `blk_load` loads `blk_len` into the counter. `eob_flag` sets after the strobe that reaches 0. `match_flag` sets after any strobe with `match_hit` = 1. Both flags stay set until `flag_clr`.
- R9: A match stop (R6) or an end-of-block stop (R7) sets `irq` in the cycle the request rises. While `irq` is 1 no request is raised. A `reti` pulse clears `irq` in the next cycle.
- R10: The block waits for `bus_ack_n` low for any number of cycles after requesting. After a release it raises no new request until `bus_ack_n` has been seen high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chan_en | input | 1 | Channel enable from the CPU |
| mode | input | 2 | 00 byte, 01 burst, 10/11 continuous |
| stop_on_match | input | 1 | Release on byte match (burst, continuous) |
| stop_on_eob | input | 1 | Release at end of block |
| dev_ready | input | 1 | Device ready line |
| force_ready | input | 1 | Force-ready command level |
| match_hit | input | 1 | Byte match for the current byte |
| blk_len | input | LEN_W | Block length to load |
| blk_load | input | 1 | Load the block counter |
| flag_clr | input | 1 | Clear the sticky flags |
| reti | input | 1 | Return-from-interrupt pulse |
| bus_ack_n | input | 1 | Bus acknowledge from the CPU, active low |
| bus_req_n | output | 1 | Bus request, active low |
| xfer_stb | output | 1 | One-cycle strobe per byte transferred |
| eob_flag | output | 1 | Sticky end-of-block flag |
| match_flag | output | 1 | Sticky byte-match flag |
| irq | output | 1 | Interrupt request, also the under-service latch |

## Verification
`xfer_stb` is combinational from the registered state and the current inputs, so it is valid in the same cycle as the inputs. `bus_req_n`, `irq` and the flags change one edge after the condition that causes them. The bench drives inputs at the falling edge and samples one time step later, so it reads each strobe in its own cycle and each release, flag and interrupt just after the edge that sets them. A model of the CPU answers a request after a delay chosen per case, from 3 to 11 cycles, and drops acknowledge one clock after the request rises. A separate test holds acknowledge low longer to check R10.

// File: rtl/dma_busreq_pkg.sv
package dma_busreq_pkg;

    typedef enum logic [1:0] {
        MODE_BYTE     = 2'b00,
        MODE_BURST    = 2'b01,
        MODE_CONT     = 2'b10,
        MODE_CONT_ALT = 2'b11
    } xfer_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_REQ,
        ST_OWN,
        ST_REL
    } bus_state_e;

    typedef struct packed {
        logic byte_done;
        logic ready_lost;
        logic match_stop;
        logic eob_stop;
    } stop_cause_t;

    function automatic logic is_byte_mode(xfer_mode_e m);
        return m == MODE_BYTE;
    endfunction

    function automatic logic holds_on_unready(xfer_mode_e m);
        return m[1];
    endfunction

endpackage

// File: rtl/dma_blk_counter.sv
module dma_blk_counter #(
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [LEN_W-1:0] load_val,
    input  logic             step,
    output logic             at_one
);
    localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

    logic [LEN_W-1:0] remaining;

    always_ff @(posedge clk) begin
        if (rst) begin
            remaining <= '0;
        end else if (load) begin
            remaining <= load_val;
        end else if (step && remaining != '0) begin
            remaining <= remaining - ONE;
        end
    end

    assign at_one = (remaining == ONE);
endmodule

// File: rtl/dma_irq_latch.sv
module dma_irq_latch (
    input  logic clk,
    input  logic rst,
    input  logic stop_irq,
    input  logic reti,
    input  logic stb,
    input  logic at_one,
    input  logic match_hit,
    input  logic flag_clr,
    output logic in_service,
    output logic eob_flag,
    output logic match_flag
);
    always_ff @(posedge clk) begin
        if (rst) begin
            in_service <= 1'b0;
            eob_flag   <= 1'b0;
            match_flag <= 1'b0;
        end else begin
            if (stop_irq)
                in_service <= 1'b1;
            else if (reti)
                in_service <= 1'b0;

            if (stb && at_one)
                eob_flag <= 1'b1;
            else if (flag_clr)
                eob_flag <= 1'b0;

            if (stb && match_hit)
                match_flag <= 1'b1;
            else if (flag_clr)
                match_flag <= 1'b0;
        end
    end
endmodule

// File: rtl/dma_bus_fsm.sv
module dma_bus_fsm
    import dma_busreq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       chan_en,
    input  xfer_mode_e mode,
    input  logic       ready,
    input  logic       stop_on_match,
    input  logic       stop_on_eob,
    input  logic       match_hit,
    input  logic       at_one,
    input  logic       in_service,
    input  logic       bus_ack_n,
    output logic       bus_req_n,
    output logic       xfer_stb,
    output logic       stop_irq,
    output logic       own
);
    bus_state_e  state, state_nx;
    stop_cause_t cause;
    logic        stop;

    always_comb begin
        own      = (state == ST_OWN);
        xfer_stb = own && !bus_ack_n && ready;

        cause.byte_done  = xfer_stb && is_byte_mode(mode);
        cause.ready_lost = own && !ready && !holds_on_unready(mode);
        cause.match_stop = xfer_stb && match_hit && stop_on_match && !is_byte_mode(mode);
        cause.eob_stop   = xfer_stb && at_one && stop_on_eob;

        stop     = |cause;
        stop_irq = cause.match_stop || cause.eob_stop;
    end

    always_comb begin
        state_nx = state;
        case (state)
            ST_IDLE: if (chan_en && ready && !in_service && bus_ack_n) state_nx = ST_REQ;
            ST_REQ:  if (!bus_ack_n) state_nx = ST_OWN;
            ST_OWN:  if (stop) state_nx = ST_REL;
            ST_REL:  if (bus_ack_n) state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            state <= ST_IDLE;
        else
            state <= state_nx;
    end

    assign bus_req_n = !(state == ST_REQ || state == ST_OWN);
endmodule

// File: rtl/dma_busreq_ctrl.sv
module dma_busreq_ctrl
    import dma_busreq_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             chan_en,
    input  logic [1:0]       mode,
    input  logic             stop_on_match,
    input  logic             stop_on_eob,
    input  logic             dev_ready,
    input  logic             force_ready,
    input  logic             match_hit,
    input  logic [LEN_W-1:0] blk_len,
    input  logic             blk_load,
    input  logic             flag_clr,
    input  logic             reti,
    input  logic             bus_ack_n,
    output logic             bus_req_n,
    output logic             xfer_stb,
    output logic             eob_flag,
    output logic             match_flag,
    output logic             irq
);
    logic ready;
    logic at_one;
    logic stop_irq;
    logic own_bus;

    assign ready = dev_ready || force_ready;

    dma_blk_counter #(.LEN_W(LEN_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .load     (blk_load),
        .load_val (blk_len),
        .step     (xfer_stb),
        .at_one   (at_one)
    );

    dma_bus_fsm u_fsm (
        .clk           (clk),
        .rst           (rst),
        .chan_en       (chan_en),
        .mode          (xfer_mode_e'(mode)),
        .ready         (ready),
        .stop_on_match (stop_on_match),
        .stop_on_eob   (stop_on_eob),
        .match_hit     (match_hit),
        .at_one        (at_one),
        .in_service    (irq),
        .bus_ack_n     (bus_ack_n),
        .bus_req_n     (bus_req_n),
        .xfer_stb      (xfer_stb),
        .stop_irq      (stop_irq),
        .own           (own_bus)
    );

    dma_irq_latch u_irq (
        .clk        (clk),
        .rst        (rst),
        .stop_irq   (stop_irq),
        .reti       (reti),
        .stb        (xfer_stb),
        .at_one     (at_one),
        .match_hit  (match_hit),
        .flag_clr   (flag_clr),
        .in_service (irq),
        .eob_flag   (eob_flag),
        .match_flag (match_flag)
    );
endmodule

// File: rtl/dma_busreq_chk.sv
module dma_busreq_chk (
    input logic       clk,
    input logic       rst,
    input logic       chan_en,
    input logic [1:0] mode,
    input logic       stop_on_match,
    input logic       dev_ready,
    input logic       force_ready,
    input logic       match_hit,
    input logic       reti,
    input logic       bus_ack_n,
    input logic       bus_req_n,
    input logic       xfer_stb,
    input logic       eob_flag,
    input logic       match_flag,
    input logic       irq,
    input logic       own_bus
);
    logic rdy;
    assign rdy = dev_ready || force_ready;

    assert_req_gate_R1: assert property (@(posedge clk) disable iff (rst)
        $fell(bus_req_n) |-> $past(chan_en && rdy && !irq && bus_ack_n));

    assert_stb_owned_R2: assert property (@(posedge clk) disable iff (rst)
        xfer_stb |-> (!bus_req_n && !bus_ack_n && rdy));

    assert_byte_release_R3: assert property (@(posedge clk) disable iff (rst)
        (xfer_stb && mode == 2'b00) |=> bus_req_n);

    assert_unready_release_R4: assert property (@(posedge clk) disable iff (rst)
        (own_bus && !rdy && !mode[1]) |=> bus_req_n);

    assert_cont_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (own_bus && !rdy && mode[1]) |=> !bus_req_n);

    assert_match_stop_R6: assert property (@(posedge clk) disable iff (rst)
        (xfer_stb && match_hit && stop_on_match && mode != 2'b00) |=> (bus_req_n && irq));

    assert_eob_origin_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(eob_flag) |-> $past(xfer_stb));

    assert_match_origin_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(match_flag) |-> $past(xfer_stb && match_hit));

    assert_irq_blocks_R9: assert property (@(posedge clk) disable iff (rst)
        (irq && bus_req_n) |=> bus_req_n);

    assert_reti_clears_R9: assert property (@(posedge clk) disable iff (rst)
        (reti && irq) |=> !irq);
endmodule

bind dma_busreq_ctrl dma_busreq_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .chan_en       (chan_en),
    .mode          (mode),
    .stop_on_match (stop_on_match),
    .dev_ready     (dev_ready),
    .force_ready   (force_ready),
    .match_hit     (match_hit),
    .reti          (reti),
    .bus_ack_n     (bus_ack_n),
    .bus_req_n     (bus_req_n),
    .xfer_stb      (xfer_stb),
    .eob_flag      (eob_flag),
    .match_flag    (match_flag),
    .irq           (irq),
    .own_bus       (own_bus)
);

// File: tb/sim_dma_busreq_ctrl.sv
`timescale 1ns/1ps
module sim_dma_busreq_ctrl;
    localparam int LEN_W = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic chan_en = 1'b0;
    logic [1:0] mode = 2'b00;
    logic stop_on_match = 1'b0;
    logic stop_on_eob = 1'b0;
    logic dev_ready = 1'b0;
    logic force_ready = 1'b0;
    logic match_hit = 1'b0;
    logic [LEN_W-1:0] blk_len = '0;
    logic blk_load = 1'b0;
    logic flag_clr = 1'b0;
    logic reti = 1'b0;
    logic bus_ack_n = 1'b1;
    logic bus_req_n, xfer_stb, eob_flag, match_flag, irq;

    int checks = 0;
    int errors = 0;
    int ack_dly = 3;
    int dly_cnt = 0;
    logic hold_ack = 1'b0;

    always #2 clk = ~clk;

    dma_busreq_ctrl #(.LEN_W(LEN_W)) u0 (
        .clk(clk), .rst(rst), .chan_en(chan_en), .mode(mode),
        .stop_on_match(stop_on_match), .stop_on_eob(stop_on_eob),
        .dev_ready(dev_ready), .force_ready(force_ready), .match_hit(match_hit),
        .blk_len(blk_len), .blk_load(blk_load), .flag_clr(flag_clr), .reti(reti),
        .bus_ack_n(bus_ack_n), .bus_req_n(bus_req_n), .xfer_stb(xfer_stb),
        .eob_flag(eob_flag), .match_flag(match_flag), .irq(irq)
    );

    // CPU model: acknowledge after ack_dly falling edges, drop one clock after release
    always @(negedge clk) begin
        if (rst) begin
            bus_ack_n <= 1'b1;
            dly_cnt   <= 0;
        end else if (!bus_req_n) begin
            if (dly_cnt >= ack_dly) bus_ack_n <= 1'b0;
            else dly_cnt <= dly_cnt + 1;
        end else if (!hold_ack) begin
            bus_ack_n <= 1'b1;
            dly_cnt   <= 0;
        end
    end

    typedef struct packed {
        logic [1:0] md;
        logic       som;
        logic       soeb;
        logic [7:0] len;
        logic [7:0] match_at;
        logic [3:0] dly;
        logic [7:0] exp_n;
        logic       exp_irq;
        logic       exp_eob;
        logic       exp_match;
    } scen_t;

    localparam int NSCEN = 7;
    localparam scen_t TBL [NSCEN] = '{
        '{2'b00, 1'b0, 1'b1, 8'd4, 8'd255, 4'd3,  8'd1, 1'b0, 1'b0, 1'b0},
        '{2'b01, 1'b0, 1'b1, 8'd5, 8'd255, 4'd11, 8'd5, 1'b1, 1'b1, 1'b0},
        '{2'b01, 1'b1, 1'b1, 8'd8, 8'd2,   4'd5,  8'd3, 1'b1, 1'b0, 1'b1},
        '{2'b10, 1'b1, 1'b0, 8'd6, 8'd3,   4'd7,  8'd4, 1'b1, 1'b0, 1'b1},
        '{2'b10, 1'b0, 1'b1, 8'd3, 8'd1,   4'd4,  8'd3, 1'b1, 1'b1, 1'b1},
        '{2'b00, 1'b1, 1'b1, 8'd2, 8'd0,   4'd9,  8'd1, 1'b0, 1'b0, 1'b1},
        '{2'b00, 1'b0, 1'b1, 8'd1, 8'd255, 4'd6,  8'd1, 1'b1, 1'b1, 1'b0}
    };

    task automatic chk(input int act, input int exp, input string tag);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic cfg(input logic [1:0] md, input logic som, input logic soeb,
                       input int len, input int dly);
        @(negedge clk);
        mode = md; stop_on_match = som; stop_on_eob = soeb;
        blk_len = LEN_W'(len); blk_load = 1'b1; flag_clr = 1'b1; ack_dly = dly;
        @(negedge clk);
        blk_load = 1'b0; flag_clr = 1'b0;
    endtask

    task automatic cleanup();
        @(negedge clk);
        reti = 1'b1; flag_clr = 1'b1;
        @(negedge clk);
        reti = 1'b0; flag_clr = 1'b0;
    endtask

    // Enables the channel and counts strobes until the request rises again
    task automatic run_xfer(input logic dev_lvl, input int match_at, input int drop_at,
                            input int drop_len, output int n);
        int paused;
        logic started;
        n = 0; paused = 0; started = 1'b0;
        chan_en = 1'b1;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            match_hit = (n == match_at);
            if (drop_at >= 0 && n >= drop_at && paused < drop_len) begin
                dev_ready = 1'b0;
                paused++;
            end else begin
                dev_ready = dev_lvl;
            end
            #1;
            if (xfer_stb) n++;
            if (!bus_req_n) started = 1'b1;
            else if (started) break;
        end
        chan_en = 1'b0; match_hit = 1'b0; dev_ready = 1'b0;
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int n;
        int hi;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        chk(bus_req_n, 1, "R1 reset request high");
        chk(xfer_stb, 0, "R2 reset strobe low");
        chk(irq, 0, "R9 reset irq low");
        chk(eob_flag + match_flag, 0, "R8 reset flags clear");

        // Disabled, then enabled without any ready source
        dev_ready = 1'b1; hi = 0;
        for (int i = 0; i < 10; i++) begin @(negedge clk); #1; hi += bus_req_n; end
        chk(hi, 10, "R1 no request while disabled");
        dev_ready = 1'b0; chan_en = 1'b1; hi = 0;
        for (int i = 0; i < 10; i++) begin @(negedge clk); #1; hi += bus_req_n; end
        chk(hi, 10, "R1 no request without ready");
        chan_en = 1'b0;

        // Table of mode / stop-option scenarios
        for (int s = 0; s < NSCEN; s++) begin
            cfg(TBL[s].md, TBL[s].som, TBL[s].soeb, int'(TBL[s].len), int'(TBL[s].dly));
            run_xfer(1'b1, (TBL[s].match_at == 8'd255) ? -1 : int'(TBL[s].match_at), -1, 0, n);
            chk(n, int'(TBL[s].exp_n), $sformatf("R3/R6/R7 scenario %0d strobe count", s));
            chk(irq, int'(TBL[s].exp_irq), $sformatf("R9 scenario %0d irq", s));
            chk(eob_flag, int'(TBL[s].exp_eob), $sformatf("R8 scenario %0d eob flag", s));
            chk(match_flag, int'(TBL[s].exp_match), $sformatf("R8 scenario %0d match flag", s));
            cleanup();
            #1;
            chk(irq + eob_flag + match_flag, 0, $sformatf("R9 scenario %0d cleared", s));
        end

        // Force-ready alone is a ready condition
        cfg(2'b00, 1'b0, 1'b0, 4, 3);
        force_ready = 1'b1;
        run_xfer(1'b0, -1, -1, 0, n);
        force_ready = 1'b0;
        chk(n, 1, "R1 force-ready request and byte transfer");
        cleanup();

        // Burst without end-of-block stop: runs past zero until ready drops
        cfg(2'b01, 1'b0, 1'b0, 3, 4);
        run_xfer(1'b1, -1, 5, 1000, n);
        chk(n, 5, "R4 burst releases on ready loss");
        chk(eob_flag, 1, "R7 eob flag without stop option");
        chk(irq, 0, "R7 no irq without stop option");
        cleanup();

        // Continuous: ready loss pauses while holding the bus
        cfg(2'b10, 1'b0, 1'b1, 4, 5);
        run_xfer(1'b1, -1, 1, 5, n);
        chk(n, 4, "R5 continuous pause keeps bus");
        chk(irq, 1, "R9 irq after continuous eob");

        // Interrupt under service blocks a new request
        mode = 2'b00; chan_en = 1'b1; dev_ready = 1'b1; hi = 0;
        for (int i = 0; i < 20; i++) begin @(negedge clk); #1; hi += bus_req_n; end
        chk(hi, 20, "R9 no request while irq set");
        chan_en = 1'b0; dev_ready = 1'b0;
        @(negedge clk); reti = 1'b1;
        @(negedge clk); reti = 1'b0; #1;
        chk(irq, 0, "R9 reti clears irq");
        cfg(2'b00, 1'b0, 1'b0, 4, 3);
        run_xfer(1'b1, -1, -1, 0, n);
        chk(n, 1, "R9 request resumes after reti");
        cleanup();

        // Acknowledge held low after release: no new request until it rises
        cfg(2'b00, 1'b0, 1'b0, 4, 10);
        hold_ack = 1'b1;
        run_xfer(1'b1, -1, -1, 0, n);
        chk(n, 1, "R10 long acknowledge delay tolerated");
        chan_en = 1'b1; dev_ready = 1'b1; hi = 0;
        for (int i = 0; i < 6; i++) begin @(negedge clk); #1; hi += bus_req_n; end
        chk(hi, 6, "R10 waits for acknowledge high");
        hold_ack = 1'b0; hi = 0;
        for (int i = 0; i < 6; i++) begin @(negedge clk); #1; if (!bus_req_n) hi = 1; end
        chk(hi, 1, "R10 request after acknowledge high");
        chan_en = 1'b0;
        repeat (30) @(negedge clk);
        dev_ready = 1'b0;
        repeat (4) @(negedge clk);
        #1;
        chk(bus_req_n, 1, "R3 byte transfer released");
        cleanup();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule